// File: doc/BRIEF.md
# USB Pipe Buffer-Empty Interrupt Logic

This block keeps one "buffer empty" status bit per pipe of a USB host/function controller. It combines those bits into a summary flag and an interrupt line. On the transmit side the packet engine reports, per pipe, that a transmission completed, whether the FIFO is now empty, whether software cleared the buffer, and whether the CPU or DMA side has already begun refilling the other plane. On the receive side it reports each good or bad packet with its size, its error flags and whether it belonged to a SETUP transaction.

A status bit can only be raised while the pipe's PID field holds BUF. Several situations suppress it: a double-buffer refill already under way, a software clear, the zero-length IN of a control status stage in function mode, and receive errors. An oversize received packet raises the status and forces the pipe's PID to STALL. It also tells the packet engine to discard the data and either to stay silent (host) or to send a STALL handshake (function). Software clears status bits by writing zeros, unmasks them through an enable register, and writes PIDs one pipe at a time.

Top module: `usb_bufempty_irq`

## Requirements
- R1: A pipe's status bit sets only if that pipe's PID is BUF (2'b01) when the event occurs. The PID encoding is NAK=2'b00, BUF=2'b01, and STALL for 2'b10 or 2'b11.
- R2: For a transmit pipe (dir_tx=1), a completed transmission with the FIFO empty sets the status on the clock edge that samples it. This holds for zero-length packets too, and for single-buffer pipes other than pipe 0.
- R3: For a double-buffered transmit pipe, completion while the refill-started flag is high raises no status. For a single-buffered pipe that flag is ignored.
- R4: A completion flagged as a software buffer clear raises no status.
- R5: On pipe 0 in function mode, completion during the control status stage raises no status. In host mode the same event does set the status.
- R6: A good receive packet on a receive pipe whose size exceeds that pipe's maximum packet size sets the status and rewrites the PID to 2'b11. It also pulses rx_discard for one cycle.
- R7: On that oversize condition, function mode pulses rx_stall_hs and host mode pulses rx_no_resp. The two are never high together.
- R8: A receive packet with a CRC error, a bit-stuffing error, a SETUP flag, or a size equal to the maximum raises no status and leaves the PID unchanged.
- R9: A status write clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R10: summary and irq equal the OR of the status bits whose enable is 1. They stay high until all enabled status bits are cleared.
- R11: A set event in the same cycle as a clearing write leaves the bit set.
- R12: After reset all status, enable, summary, irq and response outputs are 0, and every PID is NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_mode | input | 1 | 1 = function role, 0 = host role |
| dir_tx | input | NUM_PIPES | Per pipe: 1 = transmit, 0 = receive |
| dbl_buf | input | NUM_PIPES | Per pipe: 1 = double-buffer mode |
| mps_flat | input | NUM_PIPES*SIZE_W | Maximum packet size per pipe, pipe i at bits i*SIZE_W |
| tx_done | input | NUM_PIPES | Transmission completed (one-cycle pulse) |
| tx_fifo_empty | input | NUM_PIPES | FIFO empty after the transmission |
| tx_sw_clear | input | NUM_PIPES | Buffer was emptied by a software clear |
| tx_refill_started | input | NUM_PIPES | CPU/DMA already writing the other plane |
| ctrl_status_stage | input | 1 | Pipe 0 is in the control status stage |
| rx_valid | input | 1 | Received packet report (one-cycle pulse) |
| rx_pipe | input | PIPE_W | Pipe of the received packet |
| rx_size | input | SIZE_W | Received packet size in bytes |
| rx_crc_err | input | 1 | CRC error in the packet |
| rx_stuff_err | input | 1 | Bit-stuffing error in the packet |
| rx_setup | input | 1 | Packet belongs to a SETUP transaction |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_PIPES | Status write data (0 clears) |
| enb_wr | input | 1 | Enable write strobe |
| enb_wdata | input | NUM_PIPES | Enable write data |
| pid_wr | input | 1 | PID write strobe |
| pid_sel | input | PIPE_W | Pipe selected by the PID write |
| pid_wdata | input | 2 | PID value written |
| status | output | NUM_PIPES | Per-pipe buffer-empty status |
| enable | output | NUM_PIPES | Per-pipe enable |
| pid_flat | output | 2*NUM_PIPES | PID per pipe, pipe i at bits 2*i |
| summary | output | 1 | Summary status |
| irq | output | 1 | Interrupt request |
| rx_discard | output | 1 | Discard the received data |
| rx_stall_hs | output | 1 | Answer with a STALL handshake |
| rx_no_resp | output | 1 | Send no response |

## Verification
Transmit completions are applied with each suppression flag alone, so a missing or misapplied gate shows up as a status bit that should have stayed low. The same refill flag is applied on a single-buffered pipe and the same status-stage event in host mode, which separates a correct mode qualifier from a blanket suppression. Receive packets at the maximum size, one byte over, and over the maximum with each error or SETUP flag show that the comparison is strict and that errors gate both the status and the PID rewrite, in both roles. Status writes mixing 0 and 1 bits, a clear that races a set event, and enabled against disabled pipes show the write polarity, the precedence and the masking of the summary.

// File: rtl/bempty_pkg.sv
package bempty_pkg;
  localparam logic [1:0] PID_NAK   = 2'b00;
  localparam logic [1:0] PID_BUF   = 2'b01;
  localparam logic [1:0] PID_STALL = 2'b11;
endpackage

// File: rtl/bempty_tx_detect.sv
module bempty_tx_detect #(
  parameter int NUM_PIPES = 10
) (
  input  logic                 func_mode,
  input  logic                 ctrl_status_stage,
  input  logic [NUM_PIPES-1:0] dir_tx,
  input  logic [NUM_PIPES-1:0] dbl_buf,
  input  logic [NUM_PIPES-1:0] tx_done,
  input  logic [NUM_PIPES-1:0] tx_fifo_empty,
  input  logic [NUM_PIPES-1:0] tx_sw_clear,
  input  logic [NUM_PIPES-1:0] tx_refill_started,
  output logic [NUM_PIPES-1:0] tx_set
);
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic base, refill_block;
    assign base         = dir_tx[i] && tx_done[i] && tx_fifo_empty[i] && !tx_sw_clear[i];
    assign refill_block = dbl_buf[i] && tx_refill_started[i];
    if (i == 0) begin : g_dcp
      // default control pipe: the status-stage zero-length IN is silent in function role
      assign tx_set[i] = base && !refill_block && !(func_mode && ctrl_status_stage);
    end else begin : g_data
      assign tx_set[i] = base && !refill_block;
    end
  end
endmodule

// File: rtl/bempty_rx_detect.sv
module bempty_rx_detect #(
  parameter int NUM_PIPES = 10,
  parameter int SIZE_W    = 11,
  parameter int PIPE_W    = $clog2(NUM_PIPES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        func_mode,
  input  logic [NUM_PIPES-1:0]        dir_tx,
  input  logic [NUM_PIPES*SIZE_W-1:0] mps_flat,
  input  logic [NUM_PIPES-1:0]        pid_buf,
  input  logic                        rx_valid,
  input  logic [PIPE_W-1:0]           rx_pipe,
  input  logic [SIZE_W-1:0]           rx_size,
  input  logic                        rx_crc_err,
  input  logic                        rx_stuff_err,
  input  logic                        rx_setup,
  output logic [NUM_PIPES-1:0]        rx_set,
  output logic [NUM_PIPES-1:0]        hw_stall,
  output logic                        discard_q,
  output logic                        stall_hs_q,
  output logic                        no_resp_q
);
  logic good_pkt;
  assign good_pkt = rx_valid && !rx_crc_err && !rx_stuff_err && !rx_setup;

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic hit;
    assign hit       = good_pkt && !dir_tx[i] && (rx_pipe == PIPE_W'(i))
                       && (rx_size > mps_flat[i*SIZE_W +: SIZE_W]);
    assign rx_set[i]   = hit;
    assign hw_stall[i] = hit && pid_buf[i];
  end

  logic oversize;
  assign oversize = |hw_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      discard_q  <= 1'b0;
      stall_hs_q <= 1'b0;
      no_resp_q  <= 1'b0;
    end else begin
      discard_q  <= oversize;
      stall_hs_q <= oversize && func_mode;
      no_resp_q  <= oversize && !func_mode;
    end
  end

  // R7
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stall_hs_q && no_resp_q));
  // R6
  resp_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_hs_q || no_resp_q) |-> discard_q);
endmodule

// File: rtl/bempty_pid_regs.sv
module bempty_pid_regs
  import bempty_pkg::*;
#(
  parameter int NUM_PIPES = 10,
  parameter int PIPE_W    = $clog2(NUM_PIPES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pid_wr,
  input  logic [PIPE_W-1:0]      pid_sel,
  input  logic [1:0]             pid_wdata,
  input  logic [NUM_PIPES-1:0]   hw_stall,
  output logic [2*NUM_PIPES-1:0] pid_flat,
  output logic [NUM_PIPES-1:0]   pid_buf
);
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic [1:0] pid_q;
    always_ff @(posedge clk) begin
      if (rst)                                     pid_q <= PID_NAK;
      else if (hw_stall[i])                        pid_q <= PID_STALL;
      else if (pid_wr && pid_sel == PIPE_W'(i))    pid_q <= pid_wdata;
    end
    assign pid_flat[2*i +: 2] = pid_q;
    assign pid_buf[i]         = (pid_q == PID_BUF);

    // R6
    stall_rewrite_chk: assert property (@(posedge clk) disable iff (rst)
      hw_stall[i] |=> (pid_q == PID_STALL));
  end
endmodule

// File: rtl/bempty_status_regs.sv
module bempty_status_regs #(
  parameter int NUM_PIPES = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sts_wr,
  input  logic [NUM_PIPES-1:0] sts_wdata,
  input  logic                 enb_wr,
  input  logic [NUM_PIPES-1:0] enb_wdata,
  input  logic [NUM_PIPES-1:0] set_i,
  input  logic [NUM_PIPES-1:0] buf_ok,
  output logic [NUM_PIPES-1:0] status_q,
  output logic [NUM_PIPES-1:0] enable_q,
  output logic                 summary_q,
  output logic                 irq_q
);
  logic [NUM_PIPES-1:0] clr_mask, status_d, enable_d;

  always_comb begin
    clr_mask = sts_wr ? ~sts_wdata : '0;
    status_d = (status_q & ~clr_mask) | (set_i & buf_ok);
    enable_d = enb_wr ? enb_wdata : enable_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      enable_q  <= '0;
      summary_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      status_q  <= status_d;
      enable_q  <= enable_d;
      summary_q <= |(status_d & enable_d);
      irq_q     <= |(status_d & enable_d);
    end
  end

  // R10
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    (summary_q == |(status_q & enable_q)) && (irq_q == summary_q));

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_chk
    // R1
    buf_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !$past(status_q[i])) |-> $past(buf_ok[i]));
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && buf_ok[i]) |=> status_q[i]);
    // R9
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(status_q[i]) |-> $past(sts_wr && !sts_wdata[i]));
  end
endmodule

// File: rtl/usb_bufempty_irq.sv
module usb_bufempty_irq #(
  parameter int NUM_PIPES = 10,
  parameter int SIZE_W    = 11,
  parameter int PIPE_W    = $clog2(NUM_PIPES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        func_mode,
  input  logic [NUM_PIPES-1:0]        dir_tx,
  input  logic [NUM_PIPES-1:0]        dbl_buf,
  input  logic [NUM_PIPES*SIZE_W-1:0] mps_flat,
  input  logic [NUM_PIPES-1:0]        tx_done,
  input  logic [NUM_PIPES-1:0]        tx_fifo_empty,
  input  logic [NUM_PIPES-1:0]        tx_sw_clear,
  input  logic [NUM_PIPES-1:0]        tx_refill_started,
  input  logic                        ctrl_status_stage,
  input  logic                        rx_valid,
  input  logic [PIPE_W-1:0]           rx_pipe,
  input  logic [SIZE_W-1:0]           rx_size,
  input  logic                        rx_crc_err,
  input  logic                        rx_stuff_err,
  input  logic                        rx_setup,
  input  logic                        sts_wr,
  input  logic [NUM_PIPES-1:0]        sts_wdata,
  input  logic                        enb_wr,
  input  logic [NUM_PIPES-1:0]        enb_wdata,
  input  logic                        pid_wr,
  input  logic [PIPE_W-1:0]           pid_sel,
  input  logic [1:0]                  pid_wdata,
  output logic [NUM_PIPES-1:0]        status,
  output logic [NUM_PIPES-1:0]        enable,
  output logic [2*NUM_PIPES-1:0]      pid_flat,
  output logic                        summary,
  output logic                        irq,
  output logic                        rx_discard,
  output logic                        rx_stall_hs,
  output logic                        rx_no_resp
);
  logic [NUM_PIPES-1:0] tx_set, rx_set, hw_stall, pid_buf;

  bempty_tx_detect #(.NUM_PIPES(NUM_PIPES)) u_tx (
    .func_mode(func_mode), .ctrl_status_stage(ctrl_status_stage),
    .dir_tx(dir_tx), .dbl_buf(dbl_buf), .tx_done(tx_done),
    .tx_fifo_empty(tx_fifo_empty), .tx_sw_clear(tx_sw_clear),
    .tx_refill_started(tx_refill_started), .tx_set(tx_set)
  );

  bempty_rx_detect #(.NUM_PIPES(NUM_PIPES), .SIZE_W(SIZE_W), .PIPE_W(PIPE_W)) u_rx (
    .clk(clk), .rst(rst), .func_mode(func_mode), .dir_tx(dir_tx),
    .mps_flat(mps_flat), .pid_buf(pid_buf), .rx_valid(rx_valid),
    .rx_pipe(rx_pipe), .rx_size(rx_size), .rx_crc_err(rx_crc_err),
    .rx_stuff_err(rx_stuff_err), .rx_setup(rx_setup), .rx_set(rx_set),
    .hw_stall(hw_stall), .discard_q(rx_discard), .stall_hs_q(rx_stall_hs),
    .no_resp_q(rx_no_resp)
  );

  bempty_pid_regs #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) u_pid (
    .clk(clk), .rst(rst), .pid_wr(pid_wr), .pid_sel(pid_sel),
    .pid_wdata(pid_wdata), .hw_stall(hw_stall), .pid_flat(pid_flat),
    .pid_buf(pid_buf)
  );

  bempty_status_regs #(.NUM_PIPES(NUM_PIPES)) u_sts (
    .clk(clk), .rst(rst), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .enb_wr(enb_wr), .enb_wdata(enb_wdata), .set_i(tx_set | rx_set),
    .buf_ok(pid_buf), .status_q(status), .enable_q(enable),
    .summary_q(summary), .irq_q(irq)
  );
endmodule

// File: tb/test_usb_bufempty_irq.sv
`timescale 1ns/100ps
module test_usb_bufempty_irq;
  localparam int N  = 10;
  localparam int SW = 11;
  localparam int PW = $clog2(N);
  localparam int MPS = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic func_mode = 1'b0;
  logic [N-1:0] dir_tx = 10'b00_0111_1111;
  logic [N-1:0] dbl_buf = '0;
  logic [N*SW-1:0] mps_flat;
  logic [N-1:0] tx_done = '0, tx_fifo_empty = '0, tx_sw_clear = '0, tx_refill_started = '0;
  logic ctrl_status_stage = 1'b0;
  logic rx_valid = 1'b0;
  logic [PW-1:0] rx_pipe = '0;
  logic [SW-1:0] rx_size = '0;
  logic rx_crc_err = 1'b0, rx_stuff_err = 1'b0, rx_setup = 1'b0;
  logic sts_wr = 1'b0, enb_wr = 1'b0, pid_wr = 1'b0;
  logic [N-1:0] sts_wdata = '0, enb_wdata = '0;
  logic [PW-1:0] pid_sel = '0;
  logic [1:0] pid_wdata = '0;
  logic [N-1:0] status, enable;
  logic [2*N-1:0] pid_flat;
  logic summary, irq, rx_discard, rx_stall_hs, rx_no_resp;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) mps_flat[i*SW +: SW] = SW'(MPS);

  usb_bufempty_irq #(.NUM_PIPES(N), .SIZE_W(SW)) i_usb_bufempty_irq (
    .clk(clk), .rst(rst), .func_mode(func_mode), .dir_tx(dir_tx), .dbl_buf(dbl_buf),
    .mps_flat(mps_flat), .tx_done(tx_done), .tx_fifo_empty(tx_fifo_empty),
    .tx_sw_clear(tx_sw_clear), .tx_refill_started(tx_refill_started),
    .ctrl_status_stage(ctrl_status_stage), .rx_valid(rx_valid), .rx_pipe(rx_pipe),
    .rx_size(rx_size), .rx_crc_err(rx_crc_err), .rx_stuff_err(rx_stuff_err),
    .rx_setup(rx_setup), .sts_wr(sts_wr), .sts_wdata(sts_wdata), .enb_wr(enb_wr),
    .enb_wdata(enb_wdata), .pid_wr(pid_wr), .pid_sel(pid_sel), .pid_wdata(pid_wdata),
    .status(status), .enable(enable), .pid_flat(pid_flat), .summary(summary), .irq(irq),
    .rx_discard(rx_discard), .rx_stall_hs(rx_stall_hs), .rx_no_resp(rx_no_resp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_pid(input int p, input logic [1:0] v);
    @(negedge clk);
    pid_wr = 1'b1; pid_sel = PW'(p); pid_wdata = v;
    @(negedge clk);
    pid_wr = 1'b0;
  endtask

  task automatic write_sts(input logic [N-1:0] d);
    @(negedge clk);
    sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_wr = 1'b0;
  endtask

  task automatic write_enb(input logic [N-1:0] d);
    @(negedge clk);
    enb_wr = 1'b1; enb_wdata = d;
    @(negedge clk);
    enb_wr = 1'b0;
  endtask

  // one transmit completion; outputs are sampled one negedge after the edge that takes it
  task automatic tx_event(input int p, input logic clr, input logic refill);
    @(negedge clk);
    tx_done[p] = 1'b1; tx_fifo_empty[p] = 1'b1; tx_sw_clear[p] = clr; tx_refill_started[p] = refill;
    @(negedge clk);
    tx_done = '0; tx_fifo_empty = '0; tx_sw_clear = '0; tx_refill_started = '0;
  endtask

  task automatic rx_event(input int p, input int sz, input logic crc, input logic stf, input logic stp);
    @(negedge clk);
    rx_valid = 1'b1; rx_pipe = PW'(p); rx_size = SW'(sz);
    rx_crc_err = crc; rx_stuff_err = stf; rx_setup = stp;
    @(negedge clk);
    rx_valid = 1'b0; rx_crc_err = 1'b0; rx_stuff_err = 1'b0; rx_setup = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 status", status, 0);
    check("R12 enable", enable, 0);
    check("R12 pids", pid_flat, 0);
    check("R12 summary/irq", {summary, irq}, 0);
    check("R12 responses", {rx_discard, rx_stall_hs, rx_no_resp}, 0);
  endtask

  task automatic t_buf_gate();
    tx_event(3, 1'b0, 1'b0);
    check("R1 NAK pipe no status", status[3], 0);
    set_pid(3, 2'b10);
    tx_event(3, 1'b0, 1'b0);
    check("R1 STALL pipe no status", status[3], 0);
    set_pid(3, 2'b01);
    tx_event(3, 1'b0, 1'b0);
    check("R1 BUF pipe sets", status[3], 1);
    write_sts('0);
    check("R9 cleared", status[3], 0);
  endtask

  task automatic t_tx_summary();
    set_pid(5, 2'b01); set_pid(6, 2'b01); set_pid(9, 2'b01);
    tx_event(5, 1'b0, 1'b0);
    check("R2 tx complete sets", status, 10'h020);
    check("R10 disabled no irq", {summary, irq}, 0);
    write_enb(10'h060);
    check("R10 enable raises irq", {summary, irq}, 2'b11);
    tx_event(6, 1'b0, 1'b0);
    write_sts(~10'h020);
    check("R9 zero bit clears only pipe5", status, 10'h040);
    check("R10 still high with pipe6", {summary, irq}, 2'b11);
    write_sts(~10'h040);
    check("R10 all cleared low", {summary, irq}, 0);
    write_enb('0);
  endtask

  task automatic t_refill();
    set_pid(4, 2'b01);
    dbl_buf[4] = 1'b1;
    tx_event(4, 1'b0, 1'b1);
    check("R3 double-buffer refill suppresses", status[4], 0);
    tx_event(4, 1'b0, 1'b0);
    check("R3 double-buffer no refill sets", status[4], 1);
    write_sts('0);
    dbl_buf[4] = 1'b0;
    tx_event(4, 1'b0, 1'b1);
    check("R3 single-buffer ignores refill", status[4], 1);
    write_sts('0);
  endtask

  task automatic t_swclear();
    tx_event(4, 1'b1, 1'b0);
    check("R4 software clear suppresses", status[4], 0);
  endtask

  task automatic t_ctrl_stage();
    set_pid(0, 2'b01);
    ctrl_status_stage = 1'b1; func_mode = 1'b1;
    tx_event(0, 1'b0, 1'b0);
    check("R5 function status stage silent", status[0], 0);
    func_mode = 1'b0;
    tx_event(0, 1'b0, 1'b0);
    check("R5 host status stage sets", status[0], 1);
    ctrl_status_stage = 1'b0;
    write_sts('0);
  endtask

  task automatic t_rx_over();
    set_pid(7, 2'b01); set_pid(8, 2'b01);
    func_mode = 1'b1;
    rx_event(7, MPS, 1'b0, 1'b0, 1'b0);
    check("R8 size equal to max no status", status[7], 0);
    check("R8 size equal pid kept", pid_flat[15:14], 2'b01);
    @(negedge clk);
    rx_valid = 1'b1; rx_pipe = PW'(7); rx_size = SW'(MPS + 1);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R6 oversize sets", status[7], 1);
    check("R6 pid to 11", pid_flat[15:14], 2'b11);
    check("R7 function stall", {rx_discard, rx_stall_hs, rx_no_resp}, 3'b110);
    @(negedge clk);
    check("R7 response one cycle", {rx_discard, rx_stall_hs, rx_no_resp}, 3'b000);
    func_mode = 1'b0;
    @(negedge clk);
    rx_valid = 1'b1; rx_pipe = PW'(8); rx_size = SW'(MPS + 100);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R7 host no response", {rx_discard, rx_stall_hs, rx_no_resp}, 3'b101);
    check("R6 host pid to 11", pid_flat[17:16], 2'b11);
    write_sts('0);
  endtask

  task automatic t_rx_err();
    set_pid(9, 2'b01);
    rx_event(9, MPS + 1, 1'b1, 1'b0, 1'b0);
    check("R8 crc error silent", {status[9], pid_flat[19:18]}, 3'b001);
    rx_event(9, MPS + 1, 1'b0, 1'b1, 1'b0);
    check("R8 stuff error silent", {status[9], pid_flat[19:18]}, 3'b001);
    rx_event(9, MPS + 1, 1'b0, 1'b0, 1'b1);
    check("R8 setup silent", {status[9], pid_flat[19:18]}, 3'b001);
  endtask

  task automatic t_write_one();
    tx_event(2, 1'b0, 1'b0);
    check("R1 pipe2 NAK stays clear", status[2], 0);
    set_pid(2, 2'b01);
    tx_event(2, 1'b0, 1'b0);
    write_sts('1);
    check("R9 write one no effect", status[2], 1);
    write_sts('0);
    check("R9 write zero clears", status[2], 0);
  endtask

  task automatic t_race();
    @(negedge clk);
    tx_done[2] = 1'b1; tx_fifo_empty[2] = 1'b1;
    sts_wr = 1'b1; sts_wdata = '0;
    @(negedge clk);
    tx_done = '0; tx_fifo_empty = '0; sts_wr = 1'b0;
    check("R11 set wins over clear", status[2], 1);
    write_sts('0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_buf_gate();
    t_tx_summary();
    t_refill();
    t_swclear();
    t_ctrl_stage();
    t_rx_over();
    t_rx_err();
    t_write_one();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule